// File: doc/BRIEF.md
# Halt-Controlled Bus Cycle Sequencer

This block runs read and write cycles on an external bus on behalf of a processor core. An outside device can use a halt input to stop external bus activity. Holding halt and releasing it for one clock steps the bus one cycle at a time. Asserting halt together with bus error turns a failed cycle into a retry instead of an error. Requests that the core aims at internal resources bypass the external sequence and are answered whether halt is asserted or not.

Each external cycle has an address phase of one clock, with the address strobe only. It is followed by a data phase, with both strobes, that lasts until the bus sends a termination. Halt and bus error are sampled on the same edge as that termination. When a cycle ends with halt asserted, the strobes go inactive and the data drivers turn off. The address, function code, size and direction lines keep their values. When another master holds the bus, the address drivers are released. When mastership returns they are driven again with the held values. A retried cycle restarts on the clock after halt negates, with identical attributes.

The core presents a request and holds it until a one-cycle done or error pulse arrives. It changes the request in the cycle after that pulse.

Top module: `bus_halt_sequencer`

## Requirements
- R1: An internal request (req_internal=1) accepted while the sequencer is idle gives rsp_done=1 for one cycle on the next clock, with rsp_rdata=int_rdata. This happens even while halt_in is high, and as_o stays 0.
- R2: An external cycle asserts as_o alone for exactly one clock. It then asserts as_o and ds_o until ack_in or berr_in is sampled high. data_oe is high in both phases of a write (bus_read=0). On the clock after ack_in is sampled, the strobes are low and rsp_done pulses for one cycle. For a read, rsp_rdata then equals bus_data_in as it was at that edge.
- R3: On the clock after a cycle terminates with halt_in high, as_o, ds_o and data_oe are 0. They stay 0 while halt_in remains high.
- R4: bus_addr, bus_fc, bus_size and bus_read change only in the clock where a new cycle's as_o rises. addr_oe is 0 while grant_in is 1. When grant_in falls, the held values are driven again.
- R5: A termination with berr_in and halt_in both high produces neither rsp_done nor rsp_err. On the first clock with halt_in low and grant_in low, the same cycle restarts with the same address, function code, size, direction and write data.
- R6: An external cycle begins only if halt_in was low on the launching edge. With halt_in held high and released for one clock, exactly one external cycle runs.
- R7: berr_in without halt_in at termination gives rsp_err=1 for exactly one cycle, no rsp_done, and no new cycle.
- R8: When ack_in and berr_in are both high at termination, bus error takes priority: rsp_err pulses and rsp_done stays 0.
- R9: No external cycle starts while grant_in is 1. A pending request starts on the first edge after grant_in falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core request present, held until a response pulse |
| req_internal | input | 1 | Request targets an internal resource |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_fc | input | FC_W | Request function code |
| req_size | input | SIZE_W | Request transfer size |
| req_wdata | input | DATA_W | Write data |
| int_rdata | input | DATA_W | Read data from internal resources |
| rsp_done | output | 1 | One-cycle successful completion pulse |
| rsp_err | output | 1 | One-cycle bus error pulse |
| rsp_rdata | output | DATA_W | Read data returned to the core |
| halt_in | input | 1 | Halt request, active high |
| berr_in | input | 1 | Bus error, active high |
| ack_in | input | 1 | Cycle termination from the addressed device |
| grant_in | input | 1 | Bus granted to another master |
| bus_data_in | input | DATA_W | Data bus input |
| bus_addr | output | ADDR_W | Address lines |
| bus_fc | output | FC_W | Function code lines |
| bus_size | output | SIZE_W | Size lines |
| bus_read | output | 1 | Direction, 1 = read |
| addr_oe | output | 1 | Drive enable for address, function code, size and direction |
| bus_data_out | output | DATA_W | Data bus output |
| data_oe | output | 1 | Data bus drive enable; 0 means high impedance |
| as_o | output | 1 | Address strobe, active high |
| ds_o | output | 1 | Data strobe, active high |

## Verification
The bench builds the sequencer with a 20-bit address and a 16-bit data bus. At that size, addresses above bit 15 show that the held lines keep their full width across halt and grant. The data patterns make read capture and the retried write data easy to tell apart. The directed scenarios cover the following cases:
- wait states in the data phase;
- single stepping with a one-clock release;
- a halt-plus-error retry that is interrupted by a bus grant;
- an error with and without halt;
- simultaneous termination and error.

// File: rtl/bhs_pkg.sv
// Shared types for the halt-controlled bus cycle sequencer.
// Assumes: one outstanding core request at a time.
package bhs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,  // no external cycle; internal requests served here
        ST_ADDR = 2'd1,  // address phase, address strobe only
        ST_DATA = 2'd2,  // data phase, waiting for termination
        ST_HALT = 2'd3   // parked after halt+error, retry pending
    } bhs_state_t;
endpackage

// File: rtl/bhs_attr_hold.sv
// Holds the attributes of the current or most recent external cycle.
// Loads only when a new cycle is launched, so a retry or a re-drive after
// a bus grant reuses exactly the same values.
module bhs_attr_hold #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int FC_W   = 3,
    parameter int SIZE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] d_addr,
    input  logic [FC_W-1:0]   d_fc,
    input  logic [SIZE_W-1:0] d_size,
    input  logic              d_write,
    input  logic [DATA_W-1:0] d_wdata,
    output logic [ADDR_W-1:0] q_addr,
    output logic [FC_W-1:0]   q_fc,
    output logic [SIZE_W-1:0] q_size,
    output logic              q_read,
    output logic [DATA_W-1:0] q_wdata
);
    // Capture the request attributes at cycle launch, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_addr  <= '0;
            q_fc    <= '0;
            q_size  <= '0;
            q_read  <= 1'b1;
            q_wdata <= '0;
        end else if (load) begin
            q_addr  <= d_addr;
            q_fc    <= d_fc;
            q_size  <= d_size;
            q_read  <= ~d_write;
            q_wdata <= d_wdata;
        end
    end
endmodule

// File: rtl/bhs_ctrl.sv
// Cycle state machine: launches external cycles, samples termination,
// halt and bus error on the same edge, and parks for a retry.
// Assumes: grant_in is not raised in the middle of an external cycle.
module bhs_ctrl
    import bhs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_internal,
    input  logic       resp_busy,
    input  logic       halt_in,
    input  logic       berr_in,
    input  logic       ack_in,
    input  logic       grant_in,
    output bhs_state_t st_q,
    output logic       load,
    output logic       fin_ok,
    output logic       fin_err,
    output logic       int_take
);
    bhs_state_t st_nxt;

    // Next-state and one-shot event decode.
    always_comb begin
        st_nxt   = st_q;
        load     = 1'b0;
        fin_ok   = 1'b0;
        fin_err  = 1'b0;
        int_take = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (req_valid && !resp_busy) begin
                    if (req_internal) begin
                        int_take = 1'b1;
                    end else if (!halt_in && !grant_in) begin
                        load   = 1'b1;
                        st_nxt = ST_ADDR;
                    end
                end
            end
            ST_ADDR: st_nxt = ST_DATA;
            ST_DATA: begin
                if (berr_in) begin
                    if (halt_in) begin
                        st_nxt = ST_HALT;
                    end else begin
                        fin_err = 1'b1;
                        st_nxt  = ST_IDLE;
                    end
                end else if (ack_in) begin
                    fin_ok = 1'b1;
                    st_nxt = ST_IDLE;
                end
            end
            ST_HALT: begin
                if (!halt_in && !grant_in) st_nxt = ST_ADDR;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nxt;
    end

    // R2: the address phase lasts exactly one clock.
    a_r2_addr_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ADDR) |=> (st_q == ST_DATA));

    // R5: a parked retry is left only towards a new address phase.
    a_r5_halt_exit_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HALT) |=> (st_q == ST_HALT || st_q == ST_ADDR));
endmodule

// File: rtl/bhs_resp.sv
// Response register towards the core: done and error pulses plus read data.
module bhs_resp #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fin_ok,
    input  logic              fin_err,
    input  logic              int_take,
    input  logic [DATA_W-1:0] int_rdata,
    input  logic [DATA_W-1:0] bus_data_in,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);
    // Register the completion pulses and select the returned data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done  <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_done <= fin_ok | int_take;
            rsp_err  <= fin_err;
            if (int_take)    rsp_rdata <= int_rdata;
            else if (fin_ok) rsp_rdata <= bus_data_in;
        end
    end

    // R7: an error pulse lasts a single cycle.
    a_r7_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |=> !rsp_err);

    // R8: done and error never coincide.
    a_r8_done_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_done && rsp_err));
endmodule

// File: rtl/bus_halt_sequencer.sv
// Top level of the halt-controlled external bus cycle sequencer.
// Ties the state machine, the attribute holder and the response register
// together and forms the strobes and drive enables from the cycle state.
// Assumes: the core holds a request until rsp_done or rsp_err pulses.
module bus_halt_sequencer
    import bhs_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int FC_W   = 3,
    parameter int SIZE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_internal,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [FC_W-1:0]   req_fc,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] int_rdata,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              halt_in,
    input  logic              berr_in,
    input  logic              ack_in,
    input  logic              grant_in,
    input  logic [DATA_W-1:0] bus_data_in,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [FC_W-1:0]   bus_fc,
    output logic [SIZE_W-1:0] bus_size,
    output logic              bus_read,
    output logic              addr_oe,
    output logic [DATA_W-1:0] bus_data_out,
    output logic              data_oe,
    output logic              as_o,
    output logic              ds_o
);
    bhs_state_t st_q;
    logic       load, fin_ok, fin_err, int_take;

    bhs_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_internal (req_internal),
        .resp_busy    (rsp_done | rsp_err),
        .halt_in      (halt_in),
        .berr_in      (berr_in),
        .ack_in       (ack_in),
        .grant_in     (grant_in),
        .st_q         (st_q),
        .load         (load),
        .fin_ok       (fin_ok),
        .fin_err      (fin_err),
        .int_take     (int_take)
    );

    bhs_attr_hold #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .FC_W   (FC_W),
        .SIZE_W (SIZE_W)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .d_addr  (req_addr),
        .d_fc    (req_fc),
        .d_size  (req_size),
        .d_write (req_write),
        .d_wdata (req_wdata),
        .q_addr  (bus_addr),
        .q_fc    (bus_fc),
        .q_size  (bus_size),
        .q_read  (bus_read),
        .q_wdata (bus_data_out)
    );

    bhs_resp #(
        .DATA_W (DATA_W)
    ) u_resp (
        .clk         (clk),
        .rst_n       (rst_n),
        .fin_ok      (fin_ok),
        .fin_err     (fin_err),
        .int_take    (int_take),
        .int_rdata   (int_rdata),
        .bus_data_in (bus_data_in),
        .rsp_done    (rsp_done),
        .rsp_err     (rsp_err),
        .rsp_rdata   (rsp_rdata)
    );

    // Strobes and drive enables follow the cycle phase and bus ownership.
    always_comb begin
        as_o    = (st_q == ST_ADDR) || (st_q == ST_DATA);
        ds_o    = (st_q == ST_DATA);
        data_oe = as_o && !bus_read;
        addr_oe = !grant_in;
    end

    // R3: a termination under halt leaves the bus quiet on the next clock.
    a_r3_quiet_after_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_o && halt_in && (ack_in || berr_in)) |=> (!as_o && !ds_o && !data_oe));

    // R4: attribute lines move only when a new cycle's strobe rises.
    a_r4_attrs_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({bus_addr, bus_fc, bus_size, bus_read}) |-> $rose(as_o));

    // R5: halt with bus error reports nothing to the core.
    a_r5_retry_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_o && halt_in && berr_in) |=> (!rsp_done && !rsp_err));

    // R6 / R9: a cycle starts only from a released, owned bus.
    a_r6_launch_released: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(as_o) |-> $past(!halt_in && !grant_in));

    // R7: bus error without halt is reported as an error pulse.
    a_r7_err_reported: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_o && !halt_in && berr_in) |=> (rsp_err && !as_o));

    // R1: an internal completion never comes with an external strobe.
    a_r1_internal_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && !$past(ds_o)) |-> !as_o);
endmodule

// File: tb/bus_halt_sequencer_test.sv
// Directed bench for the halt-controlled bus cycle sequencer.
module bus_halt_sequencer_test;
    localparam int AW = 20;
    localparam int DW = 16;
    localparam int FW = 3;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, req_internal, req_write;
    logic [AW-1:0] req_addr;
    logic [FW-1:0] req_fc;
    logic [SW-1:0] req_size;
    logic [DW-1:0] req_wdata, int_rdata, bus_data_in;
    logic          halt_in, berr_in, ack_in, grant_in;
    logic          rsp_done, rsp_err;
    logic [DW-1:0] rsp_rdata, bus_data_out;
    logic [AW-1:0] bus_addr;
    logic [FW-1:0] bus_fc;
    logic [SW-1:0] bus_size;
    logic          bus_read, addr_oe, data_oe, as_o, ds_o;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    bus_halt_sequencer #(.ADDR_W(AW), .DATA_W(DW), .FC_W(FW), .SIZE_W(SW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_internal(req_internal),
        .req_write(req_write), .req_addr(req_addr), .req_fc(req_fc), .req_size(req_size),
        .req_wdata(req_wdata), .int_rdata(int_rdata), .rsp_done(rsp_done),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .halt_in(halt_in), .berr_in(berr_in),
        .ack_in(ack_in), .grant_in(grant_in), .bus_data_in(bus_data_in),
        .bus_addr(bus_addr), .bus_fc(bus_fc), .bus_size(bus_size), .bus_read(bus_read),
        .addr_oe(addr_oe), .bus_data_out(bus_data_out), .data_oe(data_oe),
        .as_o(as_o), .ds_o(ds_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic nclk();
        @(negedge clk);
    endtask

    task automatic settle();
        req_valid = 1'b0; req_internal = 1'b0; req_write = 1'b0;
        halt_in = 1'b0; berr_in = 1'b0; ack_in = 1'b0; grant_in = 1'b0;
        nclk(); nclk();
    endtask

    task automatic put_req(input logic intl, input logic wr, input logic [AW-1:0] a,
                           input logic [FW-1:0] fc, input logic [SW-1:0] sz,
                           input logic [DW-1:0] wd);
        req_valid = 1'b1; req_internal = intl; req_write = wr;
        req_addr = a; req_fc = fc; req_size = sz; req_wdata = wd;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        settle();
        nclk();
        chk("R2 reset as_o", 32'(as_o), 0);
        chk("R2 reset ds_o", 32'(ds_o), 0);
        chk("R2 reset data_oe", 32'(data_oe), 0);
        chk("R7 reset rsp_err", 32'(rsp_err), 0);
        chk("R4 reset addr_oe", 32'(addr_oe), 1);
        rst_n = 1'b1;
        nclk();
    endtask

    task automatic t_read_wait();
        bus_data_in = 16'hBEEF;
        put_req(1'b0, 1'b0, 20'hA2345, 3'd5, 2'd1, 16'h0);
        nclk();
        chk("R2 addr phase as_o", 32'(as_o), 1);
        chk("R2 addr phase ds_o", 32'(ds_o), 0);
        chk("R4 read addr", 32'(bus_addr), 32'hA2345);
        chk("R4 read fc", 32'(bus_fc), 5);
        chk("R2 read data_oe", 32'(data_oe), 0);
        nclk();
        chk("R2 data phase ds_o", 32'(ds_o), 1);
        for (int i = 0; i < 3; i++) begin
            nclk();
            chk("R2 wait state ds_o", 32'(ds_o), 1);
            chk("R2 wait state no done", 32'(rsp_done), 0);
        end
        ack_in = 1'b1;
        nclk();
        chk("R2 read done", 32'(rsp_done), 1);
        chk("R2 read data", 32'(rsp_rdata), 32'hBEEF);
        chk("R2 strobe off after ack", 32'(as_o), 0);
        req_valid = 1'b0; ack_in = 1'b0;
        nclk();
        chk("R2 done single pulse", 32'(rsp_done), 0);
        settle();
    endtask

    task automatic t_write();
        put_req(1'b0, 1'b1, 20'h01234, 3'd1, 2'd2, 16'h5AC3);
        nclk();
        chk("R2 write data_oe addr phase", 32'(data_oe), 1);
        chk("R2 write data out", 32'(bus_data_out), 32'h5AC3);
        chk("R4 write bus_read", 32'(bus_read), 0);
        ack_in = 1'b1;
        nclk();
        chk("R2 write data_oe data phase", 32'(data_oe), 1);
        nclk();
        chk("R2 write done", 32'(rsp_done), 1);
        chk("R2 write data_oe off", 32'(data_oe), 0);
        settle();
    endtask

    task automatic t_internal_halt();
        halt_in = 1'b1;
        int_rdata = 16'hA5A5;
        put_req(1'b1, 1'b0, 20'h00010, 3'd0, 2'd0, 16'h0);
        nclk();
        chk("R1 internal done under halt", 32'(rsp_done), 1);
        chk("R1 internal data", 32'(rsp_rdata), 32'hA5A5);
        chk("R1 internal no strobe", 32'(as_o), 0);
        req_valid = 1'b0;
        nclk();
        chk("R1 internal single pulse", 32'(rsp_done), 0);
        settle();
    endtask

    task automatic t_halt_step();
        int rises;
        int dones;
        logic prev_as;
        put_req(1'b0, 1'b0, 20'h82222, 3'd6, 2'd1, 16'h0);
        nclk();
        halt_in = 1'b1; ack_in = 1'b1;
        nclk();
        nclk();
        chk("R3 done under halt", 32'(rsp_done), 1);
        chk("R3 as_o off", 32'(as_o), 0);
        chk("R3 ds_o off", 32'(ds_o), 0);
        chk("R3 data_oe off", 32'(data_oe), 0);
        req_valid = 1'b0; ack_in = 1'b0;
        for (int i = 0; i < 3; i++) begin
            nclk();
            chk("R3 still quiet", 32'(as_o), 0);
            chk("R3 addr held", 32'(bus_addr), 32'h82222);
        end
        put_req(1'b0, 1'b0, 20'h93333, 3'd2, 2'd0, 16'h0);
        ack_in = 1'b1;
        for (int i = 0; i < 4; i++) begin
            nclk();
            chk("R6 no launch while halted", 32'(as_o), 0);
        end
        halt_in = 1'b0;
        nclk();
        halt_in = 1'b1;
        chk("R6 launch on release", 32'(as_o), 1);
        chk("R6 new addr", 32'(bus_addr), 32'h93333);
        rises = 0; dones = 0; prev_as = as_o;
        for (int i = 0; i < 8; i++) begin
            nclk();
            if (as_o && !prev_as) rises++;
            if (rsp_done) dones++;
            prev_as = as_o;
        end
        chk("R6 no extra cycle per release", 32'(rises), 0);
        chk("R6 one completion per release", 32'(dones), 1);
        settle();
    endtask

    task automatic t_retry();
        put_req(1'b0, 1'b1, 20'hC4444, 3'd2, 2'd2, 16'h1357);
        nclk();
        halt_in = 1'b1; berr_in = 1'b1;
        nclk();
        nclk();
        chk("R5 no done on retry", 32'(rsp_done), 0);
        chk("R5 no err on retry", 32'(rsp_err), 0);
        chk("R5 parked as_o", 32'(as_o), 0);
        chk("R3 parked data_oe", 32'(data_oe), 0);
        berr_in = 1'b0; grant_in = 1'b1;
        nclk();
        chk("R4 released under grant", 32'(addr_oe), 0);
        grant_in = 1'b0;
        nclk();
        chk("R4 re-driven after grant", 32'(addr_oe), 1);
        chk("R4 addr kept after grant", 32'(bus_addr), 32'hC4444);
        chk("R4 fc kept after grant", 32'(bus_fc), 2);
        halt_in = 1'b0;
        nclk();
        chk("R5 retry starts", 32'(as_o), 1);
        chk("R5 retry addr", 32'(bus_addr), 32'hC4444);
        chk("R5 retry size", 32'(bus_size), 2);
        chk("R5 retry direction", 32'(bus_read), 0);
        chk("R5 retry wdata", 32'(bus_data_out), 32'h1357);
        ack_in = 1'b1;
        nclk();
        nclk();
        chk("R5 retry completes", 32'(rsp_done), 1);
        settle();
    endtask

    task automatic t_grant_block();
        grant_in = 1'b1;
        put_req(1'b0, 1'b0, 20'h05555, 3'd1, 2'd1, 16'h0);
        for (int i = 0; i < 3; i++) begin
            nclk();
            chk("R9 no launch under grant", 32'(as_o), 0);
        end
        grant_in = 1'b0;
        nclk();
        chk("R9 launch after grant", 32'(as_o), 1);
        ack_in = 1'b1;
        nclk();
        nclk();
        chk("R9 completes", 32'(rsp_done), 1);
        settle();
    endtask

    task automatic t_berr(input logic with_ack);
        put_req(1'b0, 1'b0, 20'h06666, 3'd1, 2'd1, 16'h0);
        nclk();
        berr_in = 1'b1; ack_in = with_ack;
        nclk();
        nclk();
        if (with_ack) begin
            chk("R8 error wins", 32'(rsp_err), 1);
            chk("R8 no done", 32'(rsp_done), 0);
        end else begin
            chk("R7 error pulse", 32'(rsp_err), 1);
            chk("R7 no done", 32'(rsp_done), 0);
        end
        berr_in = 1'b0; ack_in = 1'b0; req_valid = 1'b0;
        nclk();
        chk("R7 error single cycle", 32'(rsp_err), 0);
        chk("R7 no retry", 32'(as_o), 0);
        settle();
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        req_addr = '0; req_fc = '0; req_size = '0; req_wdata = '0;
        int_rdata = '0; bus_data_in = '0;
        t_reset();
        t_read_wait();
        t_write();
        t_internal_halt();
        t_halt_step();
        t_retry();
        t_grant_block();
        t_berr(1'b0);
        t_berr(1'b1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule